// File: doc/BRIEF.md
# Iterative Decoder Run Monitor

This controller sits beside a single iterative LDPC decoder and runs it one frame at a time so that its error rate can be measured. A host fills in a frame of channel LLRs and the transmitted (golden) bits, then writes a launch command. The controller pulses a start strobe to the decoder and counts decoding iterations, at two clocks per iteration, against an iteration limit taken when the frame starts. The decoder raises `dec_done` once all parity checks pass on its current hard decisions, which ends decoding early.

Each frame gets one of three outcomes. It converged to the golden frame, it ran out of iterations, or it converged to a different valid codeword. The controller keeps this separation between a converged wrong codeword and non-convergence. On either failure it counts one frame error. It then walks the mismatch vector bit by bit and adds the differing bits to a bit error counter. The host reads the outcome, the busy flag and both counters through a small word-addressed register port.

Top module: `ldpc_run_monitor`

## Requirements
- R1: After reset the iteration limit reads 100, the golden, LLR and counter registers read 0, and the status outcome reads 0. The status busy bit is 1 during the single cycle that follows reset and 0 after that.
- R2: Host writes to address 0 (limit, low ITER_W bits), address 8 onward (golden words, word 0 holding frame bits 0..DATA_W-1) and address 16 onward (LLR words) read back unchanged. LLR word k drives `dec_llr[k*DATA_W +: DATA_W]`. Writes to addresses 2, 3, 4 and unmapped addresses change nothing. Addresses 1 and unmapped addresses read 0.
- R3: A write to address 1 arms a launch. While the controller is idle an armed launch raises `dec_start` for exactly one cycle and is consumed. A launch written while a frame is still busy is held until the controller is idle again.
- R4: Iterations take two clocks each. With limit M and no `dec_done`, decoding stops 2M+1 clocks after the edge that ends the `dec_start` cycle, and the outcome becomes give-up.
- R5: When `dec_done` is high in a decoding cycle and `dec_hard` equals the golden frame, the outcome becomes OK (1). The frame then adds no frame error and no bit errors.
- R6: When `dec_done` is high and `dec_hard` differs from the golden frame, the outcome becomes wrong-codeword (3). The frame error counter then gains 1, and the bit error counter gains the number of differing bits.
- R7: On give-up (2), the frame error counter gains 1 and the bit error counter gains the bits by which `dec_hard` differs from the golden frame in the final decoding cycle.
- R8: After a failed frame, the bit error counter rises by at most one per cycle as it scans bit 0 upward over FRAME_BITS cycles. Busy stays 1 during that scan, and the controller is idle on the cycle after the scan.
- R9: `dec_done` takes priority over the limit in the same cycle. A limit of 0 gives up in the first decoding cycle unless `dec_done` is high.
- R10: The limit is sampled when `dec_start` is high. Writing address 0 during a frame does not change that frame's give-up point.
- R11: The bit and frame error counters stop at their all-ones value instead of wrapping.
- R12: Status (address 2) holds busy in bit 2 and the outcome in bits 1:0 (0 none, 1 OK, 2 give-up, 3 wrong-codeword). The outcome clears to 0 on the edge that consumes a launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Word address for write and read |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data for `host_addr` (combinational) |
| dec_llr | output | FRAME_BITS*LLR_W | Channel LLR frame presented to the decoder |
| dec_start | output | 1 | One-cycle start strobe to the decoder |
| dec_done | input | 1 | Decoder reports all parity checks satisfied |
| dec_hard | input | FRAME_BITS | Decoder's current hard decisions |

## Verification
Frames are launched with a decoder stand-in that converges to the golden frame, converges to a frame a few bits away, or never converges. These three cases separate OK, wrong-codeword and give-up, and they show that only failures feed the counters. Limits of 0, 1, 2, 3, 4 and 100 test the two-clock iteration count. A done pulse that lands exactly on the limit checks priority, and a limit rewrite during a run checks sampling. A launch written during a bit scan, and all-bits-wrong frames that push the counter past its ceiling, exercise the held launch and saturation.

// File: rtl/dmon_pkg.sv
// Shared types and register addresses for the decoder run monitor.
// Assumes the golden words fit between GOLD_BASE and LLR_BASE.
package dmon_pkg;
    typedef enum logic [2:0] {
        ST_RESET, ST_LOAD, ST_RUN, ST_OK, ST_GIVEUP, ST_WRONG, ST_BER
    } run_state_t;

    localparam logic [1:0] VERDICT_NONE   = 2'd0;
    localparam logic [1:0] VERDICT_OK     = 2'd1;
    localparam logic [1:0] VERDICT_GIVEUP = 2'd2;
    localparam logic [1:0] VERDICT_WRONG  = 2'd3;

    localparam int ADR_MAXIT  = 0;
    localparam int ADR_LAUNCH = 1;
    localparam int ADR_STATUS = 2;
    localparam int ADR_BITERR = 3;
    localparam int ADR_FRMERR = 4;
    localparam int GOLD_BASE  = 8;
    localparam int LLR_BASE   = 16;
endpackage

// File: rtl/dmon_regs.sv
// Host register file: iteration limit, golden and LLR words, launch flag,
// read multiplexer. Assumes ITER_W <= DATA_W and that both frames are whole
// multiples of DATA_W.
module dmon_regs
    import dmon_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int ADDR_W       = 6,
    parameter int ITER_W       = 8,
    parameter int FRAME_BITS   = 16,
    parameter int LLR_W        = 4,
    parameter int CNT_W        = 16,
    parameter int MAX_ITER_RST = 100
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_wr,
    input  logic [ADDR_W-1:0]           host_addr,
    input  logic [DATA_W-1:0]           host_wdata,
    input  logic                        launch_take,
    input  logic                        busy,
    input  logic [1:0]                  outcome,
    input  logic [CNT_W-1:0]            bit_err,
    input  logic [CNT_W-1:0]            frm_err,
    output logic [ITER_W-1:0]           max_iter,
    output logic                        launch_pend,
    output logic [FRAME_BITS-1:0]       golden,
    output logic [FRAME_BITS*LLR_W-1:0] llr_frame,
    output logic [DATA_W-1:0]           host_rdata
);
    localparam int GOLD_WORDS = FRAME_BITS / DATA_W;
    localparam int LLR_WORDS  = (FRAME_BITS * LLR_W) / DATA_W;

    logic [ITER_W-1:0]                  max_q;
    logic                               pend_q;
    logic [GOLD_WORDS-1:0][DATA_W-1:0]  gold_q;
    logic [LLR_WORDS-1:0][DATA_W-1:0]   llr_q;
    logic                               hit_max;
    logic                               hit_launch;

    assign hit_max    = host_wr && (host_addr == ADDR_W'(ADR_MAXIT));
    assign hit_launch = host_wr && (host_addr == ADDR_W'(ADR_LAUNCH));

    // Iteration limit register, preset to the characterization value.
    always_ff @(posedge clk) begin
        if (!rst_n)       max_q <= ITER_W'(MAX_ITER_RST);
        else if (hit_max) max_q <= host_wdata[ITER_W-1:0];
    end

    // Launch flag: set by the host, consumed by the controller; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)           pend_q <= 1'b0;
        else if (hit_launch)  pend_q <= 1'b1;
        else if (launch_take) pend_q <= 1'b0;
    end

    for (genvar g = 0; g < GOLD_WORDS; g++) begin : g_gold
        // One golden word register.
        always_ff @(posedge clk) begin
            if (!rst_n) gold_q[g] <= '0;
            else if (host_wr && host_addr == ADDR_W'(GOLD_BASE + g)) gold_q[g] <= host_wdata;
        end
    end

    for (genvar g = 0; g < LLR_WORDS; g++) begin : g_llr
        // One LLR word register.
        always_ff @(posedge clk) begin
            if (!rst_n) llr_q[g] <= '0;
            else if (host_wr && host_addr == ADDR_W'(LLR_BASE + g)) llr_q[g] <= host_wdata;
        end
    end

    assign max_iter    = max_q;
    assign launch_pend = pend_q;
    assign golden      = gold_q;
    assign llr_frame   = llr_q;

    // Read multiplexer; unmapped addresses read zero.
    always_comb begin
        host_rdata = '0;
        if (host_addr == ADDR_W'(ADR_MAXIT))  host_rdata = DATA_W'(max_q);
        if (host_addr == ADDR_W'(ADR_STATUS)) host_rdata = DATA_W'({busy, outcome});
        if (host_addr == ADDR_W'(ADR_BITERR)) host_rdata = DATA_W'(bit_err);
        if (host_addr == ADDR_W'(ADR_FRMERR)) host_rdata = DATA_W'(frm_err);
        for (int w = 0; w < GOLD_WORDS; w++)
            if (host_addr == ADDR_W'(GOLD_BASE + w)) host_rdata = gold_q[w];
        for (int w = 0; w < LLR_WORDS; w++)
            if (host_addr == ADDR_W'(LLR_BASE + w)) host_rdata = llr_q[w];
    end

    // R3: a consumed launch is gone next cycle unless rewritten.
    p_launch_consumed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_take && !hit_launch) |=> !pend_q);
endmodule

// File: rtl/dmon_fsm.sv
// Run state machine: starts the decoder, counts two-cycle iterations against
// the limit sampled at start, and classifies the frame. Assumes dec_done and
// dec_hard are valid in every decoding cycle.
module dmon_fsm
    import dmon_pkg::*;
#(
    parameter int ITER_W     = 8,
    parameter int FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  launch_pend,
    input  logic [ITER_W-1:0]     max_iter,
    input  logic                  dec_done,
    input  logic [FRAME_BITS-1:0] dec_hard,
    input  logic [FRAME_BITS-1:0] golden,
    input  logic                  scan_done,
    output logic                  dec_start,
    output logic                  run_exit,
    output logic                  frame_fail,
    output logic                  scan_active,
    output logic                  busy,
    output logic [1:0]            outcome
);
    run_state_t        state_q, state_d;
    logic [ITER_W-1:0] iter_q, lim_q;
    logic              phase_q;
    logic [1:0]        outcome_q;

    // Next-state selection; done outranks the iteration limit.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RESET:  state_d = ST_LOAD;
            ST_LOAD:   if (launch_pend) state_d = ST_RUN;
            ST_RUN: begin
                if (dec_done)             state_d = (dec_hard == golden) ? ST_OK : ST_WRONG;
                else if (iter_q == lim_q) state_d = ST_GIVEUP;
            end
            ST_OK:     state_d = ST_LOAD;
            ST_GIVEUP: state_d = ST_BER;
            ST_WRONG:  state_d = ST_BER;
            ST_BER:    if (scan_done) state_d = ST_LOAD;
            default:   state_d = ST_RESET;
        endcase
    end

    assign dec_start   = (state_q == ST_LOAD) && launch_pend;
    assign run_exit    = (state_q == ST_RUN) && (state_d != ST_RUN);
    assign frame_fail  = run_exit && (state_d != ST_OK);
    assign scan_active = (state_q == ST_BER);
    assign busy        = launch_pend || (state_q != ST_LOAD);
    assign outcome     = outcome_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    // Iteration counter, half-iteration phase and limit sampled at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iter_q  <= '0;
            phase_q <= 1'b0;
            lim_q   <= '0;
        end else if (dec_start) begin
            iter_q  <= '0;
            phase_q <= 1'b0;
            lim_q   <= max_iter;
        end else if (state_q == ST_RUN && !run_exit) begin
            phase_q <= ~phase_q;
            if (phase_q) iter_q <= iter_q + ITER_W'(1);
        end
    end

    // Outcome code: cleared at launch, set when decoding ends.
    always_ff @(posedge clk) begin
        if (!rst_n)         outcome_q <= VERDICT_NONE;
        else if (dec_start) outcome_q <= VERDICT_NONE;
        else if (run_exit) begin
            case (state_d)
                ST_OK:     outcome_q <= VERDICT_OK;
                ST_WRONG:  outcome_q <= VERDICT_WRONG;
                default:   outcome_q <= VERDICT_GIVEUP;
            endcase
        end
    end

    // R3: a start strobe always leads into decoding.
    p_start_enters_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_start |=> state_q == ST_RUN);
    // R4: the counter never passes the sampled limit.
    p_iter_in_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUN |-> iter_q <= lim_q);
    // R5: OK only follows a done with a matching frame.
    p_ok_needs_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_OK |-> $past(dec_done && dec_hard == golden));
    // R9: give-up only at the limit and never alongside done.
    p_giveup_at_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_GIVEUP |-> ($past(iter_q) == $past(lim_q)) && !$past(dec_done));
    // R10: the limit holds still while decoding.
    p_limit_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_RUN) |-> $stable(lim_q));
endmodule

// File: rtl/dmon_err_acc.sv
// Error accumulation: captures the mismatch vector when decoding ends, scans
// it one bit per cycle from bit 0, and keeps saturating bit and frame counts.
module dmon_err_acc #(
    parameter int FRAME_BITS = 16,
    parameter int CNT_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_exit,
    input  logic                  frame_fail,
    input  logic                  scan_active,
    input  logic [FRAME_BITS-1:0] dec_hard,
    input  logic [FRAME_BITS-1:0] golden,
    output logic                  scan_done,
    output logic [CNT_W-1:0]      bit_err,
    output logic [CNT_W-1:0]      frm_err
);
    localparam int IDX_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;

    logic [FRAME_BITS-1:0] diff_q;
    logic [IDX_W-1:0]      idx_q;
    logic [CNT_W-1:0]      bit_err_q, frm_err_q;

    assign scan_done = scan_active && (idx_q == IDX_W'(FRAME_BITS - 1));
    assign bit_err   = bit_err_q;
    assign frm_err   = frm_err_q;

    // Capture the mismatch vector at the end of decoding.
    always_ff @(posedge clk) begin
        if (!rst_n)        diff_q <= '0;
        else if (run_exit) diff_q <= dec_hard ^ golden;
    end

    // Scan position, restarting at bit 0 for every scan.
    always_ff @(posedge clk) begin
        if (!rst_n || !scan_active) idx_q <= '0;
        else if (scan_done)         idx_q <= '0;
        else                        idx_q <= idx_q + IDX_W'(1);
    end

    // Saturating bit error count, one bit examined per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) bit_err_q <= '0;
        else if (scan_active && diff_q[idx_q] && bit_err_q != '1)
            bit_err_q <= bit_err_q + CNT_W'(1);
    end

    // Saturating frame error count.
    always_ff @(posedge clk) begin
        if (!rst_n) frm_err_q <= '0;
        else if (frame_fail && frm_err_q != '1)
            frm_err_q <= frm_err_q + CNT_W'(1);
    end

    // R8: the bit count climbs by at most one per cycle.
    p_bit_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_err_q == $past(bit_err_q)) || (bit_err_q == $past(bit_err_q) + CNT_W'(1)));
    // R8: outside a scan the bit count does not move.
    p_bit_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(scan_active) |-> $stable(bit_err_q));
    // R11: a full frame counter stays full.
    p_frm_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frm_err_q) == '1) |-> (frm_err_q == '1));
endmodule

// File: rtl/ldpc_run_monitor.sv
// Top of the decoder run monitor: host registers, run state machine and
// error accumulation for one iterative decoder. Assumes the decoder samples
// dec_llr on dec_start and keeps dec_hard current while decoding.
module ldpc_run_monitor
    import dmon_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int ADDR_W       = 6,
    parameter int ITER_W       = 8,
    parameter int FRAME_BITS   = 16,
    parameter int LLR_W        = 4,
    parameter int CNT_W        = 16,
    parameter int MAX_ITER_RST = 100
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_wr,
    input  logic [ADDR_W-1:0]           host_addr,
    input  logic [DATA_W-1:0]           host_wdata,
    output logic [DATA_W-1:0]           host_rdata,
    output logic [FRAME_BITS*LLR_W-1:0] dec_llr,
    output logic                        dec_start,
    input  logic                        dec_done,
    input  logic [FRAME_BITS-1:0]       dec_hard
);
    logic [ITER_W-1:0]     max_iter;
    logic                  launch_pend;
    logic [FRAME_BITS-1:0] golden;
    logic                  run_exit, frame_fail, scan_active, scan_done, busy;
    logic [1:0]            outcome;
    logic [CNT_W-1:0]      bit_err, frm_err;

    dmon_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ITER_W(ITER_W), .FRAME_BITS(FRAME_BITS),
        .LLR_W(LLR_W), .CNT_W(CNT_W), .MAX_ITER_RST(MAX_ITER_RST)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .launch_take(dec_start), .busy(busy),
        .outcome(outcome), .bit_err(bit_err), .frm_err(frm_err),
        .max_iter(max_iter), .launch_pend(launch_pend), .golden(golden),
        .llr_frame(dec_llr), .host_rdata(host_rdata)
    );

    dmon_fsm #(.ITER_W(ITER_W), .FRAME_BITS(FRAME_BITS)) fsm_i (
        .clk(clk), .rst_n(rst_n), .launch_pend(launch_pend), .max_iter(max_iter),
        .dec_done(dec_done), .dec_hard(dec_hard), .golden(golden),
        .scan_done(scan_done), .dec_start(dec_start), .run_exit(run_exit),
        .frame_fail(frame_fail), .scan_active(scan_active), .busy(busy),
        .outcome(outcome)
    );

    dmon_err_acc #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) acc_i (
        .clk(clk), .rst_n(rst_n), .run_exit(run_exit), .frame_fail(frame_fail),
        .scan_active(scan_active), .dec_hard(dec_hard), .golden(golden),
        .scan_done(scan_done), .bit_err(bit_err), .frm_err(frm_err)
    );
endmodule

// File: tb/ldpc_run_monitor_tb_top.sv
// Bench: behavioural model with integer state, compared on every clock.
module ldpc_run_monitor_tb_top;
    localparam int FB = 16, LW = 4, DW = 16, IW = 8, CW = 6, AW = 6;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic [FB*LW-1:0] dec_llr;
    logic          dec_start;
    logic          dec_done = 1'b0;
    logic [FB-1:0] dec_hard = '0;

    int n_cmp = 0, n_bad = 0, cyc = 0, rot_i = 0;
    string cur_req = "R1";

    ldpc_run_monitor #(.DATA_W(DW), .ADDR_W(AW), .ITER_W(IW), .FRAME_BITS(FB),
                       .LLR_W(LW), .CNT_W(CW), .MAX_ITER_RST(100)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .dec_llr(dec_llr),
        .dec_start(dec_start), .dec_done(dec_done), .dec_hard(dec_hard)
    );

    always #4 clk = ~clk;

    // Model state: 0 reset, 1 idle, 2 decoding, 3 ok, 4 give-up, 5 wrong, 6 scan.
    int m_mode = 0, m_max = 100, m_lim = 0, m_runc = 0, m_out = 0;
    int m_berr = 0, m_ferr = 0, m_idx = 0;
    bit m_pend = 0;
    logic [FB-1:0] m_gold = '0, m_errv = '0;
    logic [DW-1:0] m_llr [4];

    always @(posedge clk) begin
        bit st;
        if (!rst_n) begin
            m_mode = 0; m_max = 100; m_lim = 0; m_runc = 0; m_out = 0;
            m_berr = 0; m_ferr = 0; m_idx = 0; m_pend = 0; m_gold = '0; m_errv = '0;
            for (int k = 0; k < 4; k++) m_llr[k] = '0;
        end else begin
            st = (m_mode == 1) && m_pend;
            case (m_mode)
                0: m_mode = 1;
                1: if (m_pend) begin m_mode = 2; m_runc = 0; m_lim = m_max; m_out = 0; end
                2: begin
                    if (dec_done) begin
                        m_errv = dec_hard ^ m_gold;
                        if (dec_hard == m_gold) begin m_mode = 3; m_out = 1; end
                        else begin m_mode = 5; m_out = 3; if (m_ferr < CMAX) m_ferr++; end
                    end else if (m_runc == 2 * m_lim) begin
                        m_errv = dec_hard ^ m_gold;
                        m_mode = 4; m_out = 2; if (m_ferr < CMAX) m_ferr++;
                    end else m_runc++;
                end
                3: m_mode = 1;
                4, 5: begin m_mode = 6; m_idx = 0; end
                default: begin
                    if (m_errv[m_idx] && m_berr < CMAX) m_berr++;
                    if (m_idx == FB - 1) begin m_mode = 1; m_idx = 0; end
                    else m_idx++;
                end
            endcase
            if (st) m_pend = 0;
            if (host_wr) begin
                if (host_addr == 0) m_max = int'(host_wdata[IW-1:0]);
                if (host_addr == 1) m_pend = 1;
                if (host_addr == 8) m_gold = host_wdata;
                if (host_addr >= 16 && host_addr < 20) m_llr[host_addr - 16] = host_wdata;
            end
        end
    end

    function automatic int exp_rd(input int a);
        int busy;
        busy = (m_pend || m_mode != 1) ? 1 : 0;
        case (a)
            0: return m_max;
            2: return busy * 4 + m_out;
            3: return m_berr;
            4: return m_ferr;
            8: return int'(m_gold);
            16, 17, 18, 19: return int'(m_llr[a - 16]);
            default: return 0;
        endcase
    endfunction

    task automatic check(input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // Per-clock comparison, one time unit after the edge.
    always @(posedge clk) begin
        #1;
        check("dec_start", longint'(dec_start), (m_mode == 1 && m_pend) ? 1 : 0);
        check($sformatf("rdata@%0d", host_addr), longint'(host_rdata), longint'(exp_rd(int'(host_addr))));
        check("dec_llr", longint'(dec_llr), longint'({m_llr[3], m_llr[2], m_llr[1], m_llr[0]}));
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog %s: actual %0d expected below 150000 cycles", cur_req, cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic logic [AW-1:0] rot(input int i);
        case (i % 12)
            0: return 0;  1: return 2;  2: return 3;  3: return 4;
            4: return 8;  5: return 16; 6: return 17; 7: return 18;
            8: return 19; 9: return 1;  10: return 40; default: return 2;
        endcase
    endfunction

    task automatic step();
        @(negedge clk);
        host_wr = 1'b0; dec_done = 1'b0; host_addr = rot(rot_i); rot_i++;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = AW'(a); host_wdata = DW'(d); dec_done = 1'b0;
    endtask

    task automatic done_step(input logic [FB-1:0] h);
        @(negedge clk);
        host_wr = 1'b0; dec_done = 1'b1; dec_hard = h; host_addr = rot(rot_i); rot_i++;
    endtask

    task automatic wait_run();
        step();
        while (m_mode != 2) step();
    endtask

    task automatic wait_idle();
        step();
        while (!(m_mode == 1 && !m_pend)) step();
        repeat (3) step();
    endtask

    initial begin
        logic [FB-1:0] g;
        g = 16'hA5C3;
        // R1: reset state, busy only in the cycle after reset.
        cur_req = "R1";
        repeat (3) step();
        rst_n = 1'b1;
        repeat (14) step();
        // R2: register write/readback, LLR mapping, ignored writes.
        cur_req = "R2";
        wr(0, 7); wr(8, int'(g));
        wr(16, 16'h1234); wr(17, 16'h5678); wr(18, 16'h9ABC); wr(19, 16'hDEF0);
        wr(2, 16'hFFFF); wr(3, 16'hFFFF); wr(4, 16'hFFFF); wr(40, 16'h7777);
        repeat (14) step();
        // R5 and R12: converges to the golden frame.
        cur_req = "R5";
        wr(1, 0); wait_run(); repeat (3) step(); done_step(g); wait_idle();
        // R6: converges to another codeword, 3 bits off.
        cur_req = "R6";
        wr(1, 0); wait_run(); repeat (5) step(); done_step(g ^ 16'h0109); wait_idle();
        // R7 and R4: give-up with limit 3, 4 bits off.
        cur_req = "R7";
        dec_hard = g ^ 16'h8421;
        wr(0, 3); wr(1, 0); wait_idle();
        // R4: default-sized limit of 100, hard decisions correct.
        cur_req = "R4";
        dec_hard = g;
        wr(0, 100); wr(1, 0); wait_idle();
        // R9: limit 0 gives up at once.
        cur_req = "R9";
        dec_hard = g ^ 16'h0003;
        wr(0, 0); wr(1, 0); wait_idle();
        // R9: done lands on the limit cycle and wins.
        wr(0, 2); wr(1, 0); wait_run(); repeat (3) step(); done_step(g); wait_idle();
        // R10: limit rewritten during the frame.
        cur_req = "R10";
        dec_hard = g;
        wr(0, 4); wr(1, 0); wait_run(); wr(0, 1); wait_idle();
        // R3 and R8: launch armed during a bit scan is held.
        cur_req = "R3";
        dec_hard = ~g;
        wr(0, 1); wr(1, 0);
        step();
        while (m_mode != 6) step();
        cur_req = "R8";
        repeat (4) step();
        wr(1, 0); wait_idle();
        // R11: push the bit counter past its ceiling.
        cur_req = "R11";
        wr(1, 0); wait_idle();
        wr(1, 0); wait_idle();
        check("R11 bit count saturated", longint'(m_berr), longint'(CMAX));
        repeat (4) step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule